// File: doc/BRIEF.md
# Auto-Reload Timer with Prescaler

An 8-bit up-counting timer. A clock multiplexer picks where count events come from: every cycle of the internal clock, every third internal cycle, or edges seen on an external timer input. A binary prescaler then passes one event in 2^N. When the counter rolls past its maximum it takes the reload value and raises a sticky overflow flag. It also raises a sticky compare flag when it steps onto the value held in the compare register.

Software reaches the block through a byte-wide register port with four addresses: control, reload, compare and a load window. A read of the load window returns the live counter. A write to it replaces the counter at once, while the timer keeps running. The external input passes through a two-stage synchronizer. Edge detection on it has its own enable bit and its own polarity bit. Software clears each flag with a one-cycle strobe.

Top module: `art8_timer`

## Requirements
- R1: While reset is held, the control, reload, compare and load-window reads all return 0x00, and both flags are low.
- R2: Control 0x00 (internal source, prescale field 0) advances the counter by one on every clock.
- R3: Control bits [7:5] = N give one counter step per 2^N source events (N=3: 8 cycles, N=7: 128 cycles).
- R4: A write to the control register does not restart the prescaler. Its phase carries on across the write.
- R5: Source code 01 in control bits [1:0] gives one source event every third clock.
- R6: Source code 10 with bit 2 set and bit 3 clear counts each rising edge of `ext_in` once.
- R7: Source code 10 with bits 2 and 3 both set counts each falling edge of `ext_in` once and ignores rising edges.
- R8: Source code 10 with bit 2 clear ignores `ext_in`, and the counter does not move.
- R9: Source code 11 stops the counter.
- R10: A step taken from 0xFF loads the reload register (address 0xD9) and sets `ovf_flag`. The flag stays set until `flag_clr[0]` is pulsed.
- R11: A read of address 0xDB returns the counter. A write to it replaces the counter in the next cycle, and this takes precedence over a step in that cycle.
- R12: A step onto the value in the compare register (address 0xDA) sets `cmp_flag`. The flag stays set after the counter moves on, until `flag_clr[1]` is pulsed.
- R13: Control bit 4 (address 0xD7) always reads 0, even when it is written as 1.
- R14: A write to an address other than 0xD7, 0xD9, 0xDA or 0xDB changes no register, and a read from such an address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| ext_in | input | 1 | External timer input (asynchronous) |
| flag_clr | input | 2 | Flag clear strobes: bit 0 for overflow, bit 1 for compare |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_flag | output | 1 | Sticky compare-match flag |

## Verification
The bench finds the prescaler's phase by watching for a counter step. It then rewrites the control register part-way through a period and expects the next step exactly eight cycles after the previous one. A design that resets the prescaler on a control write would take twelve cycles. The external-input tests end on one extra rising edge. This separates the two polarities by count: a swapped polarity bit gives 5 instead of 6, or the reverse. The overflow test checks the step from 0xFF lands on the reload value rather than zero. A load write lands during running counting, so a design that let the step win would read 0x41 instead of 0x40.

// File: rtl/art_pkg.sv
package art_pkg;
  localparam int PRE_W = 7;
  localparam int SEL_W = 3;

  typedef enum logic [1:0] {
    SRC_INT  = 2'b00,
    SRC_DIV3 = 2'b01,
    SRC_EXT  = 2'b10,
    SRC_OFF  = 2'b11
  } src_e;

  typedef struct packed {
    logic [SEL_W-1:0] psel;
    logic             rsvd;
    logic             edge_fall;
    logic             edge_en;
    src_e             src;
  } ctrl_t;

  // true when the low 'sel' bits of the prescale count are all ones
  function automatic logic tap_hit(input logic [PRE_W-1:0] pre, input logic [SEL_W-1:0] sel);
    logic [PRE_W-1:0] mask;
    mask = (PRE_W'(1) << sel) - PRE_W'(1);
    return (pre & mask) == mask;
  endfunction
endpackage

// File: rtl/art_src_sel.sv
module art_src_sel
  import art_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  src_e src,
  input  logic edge_en,
  input  logic edge_fall,
  input  logic ext_in,
  output logic src_en
);
  logic [1:0]             div_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   div3_pulse;
  logic                   lvl, rise, fall, ext_pulse;

  always_ff @(posedge clk) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= (div_q == 2'd2) ? 2'd0 : div_q + 2'd1;
  end
  assign div3_pulse = (div_q == 2'd2);

  genvar g;
  for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= ext_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else        sync_q[g] <= sync_q[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= lvl;
  end

  assign lvl       = sync_q[SYNC_STAGES-1];
  assign rise      = lvl & ~last_q;
  assign fall      = ~lvl & last_q;
  assign ext_pulse = edge_en & (edge_fall ? fall : rise);

  always_comb begin
    case (src)
      SRC_INT:  src_en = 1'b1;
      SRC_DIV3: src_en = div3_pulse;
      SRC_EXT:  src_en = ext_pulse;
      default:  src_en = 1'b0;
    endcase
  end
endmodule

// File: rtl/art_prescaler.sv
module art_prescaler
  import art_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_en,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [PRE_W-1:0] pre_q;

  // the count runs on regardless of sel; sel only picks the tap
  always_ff @(posedge clk) begin
    if (!rst_n)      pre_q <= '0;
    else if (src_en) pre_q <= pre_q + PRE_W'(1);
  end

  assign tick = src_en & tap_hit(pre_q, sel);
endmodule

// File: rtl/art8_timer.sv
module art8_timer
  import art_pkg::*;
#(
  parameter int          W        = 8,
  parameter logic [7:0]  A_CTRL   = 8'hD7,
  parameter logic [7:0]  A_RELOAD = 8'hD9,
  parameter logic [7:0]  A_CMP    = 8'hDA,
  parameter logic [7:0]  A_LOAD   = 8'hDB
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [7:0]   bus_addr,
  input  logic         bus_wr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic         ext_in,
  input  logic [1:0]   flag_clr,
  output logic         ovf_flag,
  output logic         cmp_flag
);
  localparam logic [W-1:0] CNT_MAX = '1;

  ctrl_t        ctrl_q;
  logic [W-1:0] reload_q, cmp_q, cnt_q, cnt_nxt;
  logic         ctrl_wr, reload_wr, cmp_wr, load_wr;
  logic         src_en, cnt_tick, ovf_evt, cmp_evt;
  logic         ovf_q, cmpf_q;

  function automatic logic [W-1:0] bump(input logic [W-1:0] c, input logic [W-1:0] r);
    return (c == CNT_MAX) ? r : c + W'(1);
  endfunction

  assign ctrl_wr   = bus_wr && (bus_addr == A_CTRL);
  assign reload_wr = bus_wr && (bus_addr == A_RELOAD);
  assign cmp_wr    = bus_wr && (bus_addr == A_CMP);
  assign load_wr   = bus_wr && (bus_addr == A_LOAD);

  art_src_sel #(.SYNC_STAGES(2)) u_src (
    .clk       (clk),
    .rst_n     (rst_n),
    .src       (ctrl_q.src),
    .edge_en   (ctrl_q.edge_en),
    .edge_fall (ctrl_q.edge_fall),
    .ext_in    (ext_in),
    .src_en    (src_en)
  );

  art_prescaler u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_en (src_en),
    .sel    (ctrl_q.psel),
    .tick   (cnt_tick)
  );

  assign cnt_nxt = bump(cnt_q, reload_q);
  assign ovf_evt = cnt_tick && !load_wr && (cnt_q == CNT_MAX);
  assign cmp_evt = cnt_tick && !load_wr && (cnt_nxt == cmp_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      cmp_q    <= '0;
    end else begin
      if (ctrl_wr)   ctrl_q   <= ctrl_t'({bus_wdata[7:5], 1'b0, bus_wdata[3:0]});
      if (reload_wr) reload_q <= bus_wdata;
      if (cmp_wr)    cmp_q    <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (load_wr)  cnt_q <= bus_wdata;
    else if (cnt_tick) cnt_q <= cnt_nxt;
  end

  // a set in the same cycle as a clear wins
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_q  <= 1'b0;
      cmpf_q <= 1'b0;
    end else begin
      ovf_q  <= ovf_evt | (ovf_q  & ~flag_clr[0]);
      cmpf_q <= cmp_evt | (cmpf_q & ~flag_clr[1]);
    end
  end

  assign ovf_flag = ovf_q;
  assign cmp_flag = cmpf_q;

  always_comb begin
    bus_rdata = '0;
    if      (bus_addr == A_CTRL)   bus_rdata = W'(ctrl_q);
    else if (bus_addr == A_RELOAD) bus_rdata = reload_q;
    else if (bus_addr == A_CMP)    bus_rdata = cmp_q;
    else if (bus_addr == A_LOAD)   bus_rdata = cnt_q;
  end
endmodule

// File: rtl/art8_timer_chk.sv
module art8_timer_chk #(
  parameter int         W      = 8,
  parameter logic [7:0] A_CTRL = 8'hD7
) (
  input logic         clk,
  input logic         rst_n,
  input logic [7:0]   ctrl,
  input logic [W-1:0] cnt,
  input logic [W-1:0] reload,
  input logic [W-1:0] wdata,
  input logic [W-1:0] rdata,
  input logic [7:0]   addr,
  input logic         tick,
  input logic         load_wr,
  input logic [1:0]   flag_clr,
  input logic         ovf_flag,
  input logic         cmp_flag
);
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load_wr && cnt != '1) |=> cnt == $past(cnt) + W'(1));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load_wr) |=> $stable(cnt));

  p_div1_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[7:5] == 3'd0 && ctrl[1:0] == 2'b00) |-> tick);

  p_ext_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[1:0] == 2'b10 && !ctrl[2]) |-> !tick);

  p_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[1:0] == 2'b11) |-> !tick);

  p_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load_wr && cnt == '1) |=> (cnt == $past(reload) && ovf_flag));

  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !flag_clr[0]) |=> ovf_flag);

  p_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    load_wr |=> cnt == $past(wdata));

  p_cmp_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_flag && !flag_clr[1]) |=> cmp_flag);

  p_rsvd_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_CTRL) |-> !rdata[4]);
endmodule

bind art8_timer art8_timer_chk #(.W(W), .A_CTRL(A_CTRL)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ctrl     (ctrl_q),
  .cnt      (cnt_q),
  .reload   (reload_q),
  .wdata    (bus_wdata),
  .rdata    (bus_rdata),
  .addr     (bus_addr),
  .tick     (cnt_tick),
  .load_wr  (load_wr),
  .flag_clr (flag_clr),
  .ovf_flag (ovf_flag),
  .cmp_flag (cmp_flag)
);

// File: tb/tb_art8_timer.sv
`timescale 1ns/1ps
module tb_art8_timer;
  localparam logic [7:0] A_CTRL = 8'hD7, A_RELOAD = 8'hD9, A_CMP = 8'hDA, A_LOAD = 8'hDB;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = A_LOAD;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       ext_in = 1'b0;
  logic [1:0] flag_clr = 2'b00;
  logic       ovf_flag, cmp_flag;
  int         n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  art8_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_in(ext_in),
    .flag_clr(flag_clr), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = A_LOAD;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_wr = 1'b0; flag_clr = 2'b00; bus_addr = A_LOAD;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // waits until the counter steps; gap = negedges taken
  task automatic wait_change(output int gap);
    logic [7:0] a, b;
    rd(A_LOAD, a);
    gap = -1;
    for (int k = 1; k <= 300; k++) begin
      @(negedge clk);
      rd(A_LOAD, b);
      if (b != a) begin gap = k; break; end
    end
  endtask

  task automatic t_reset_r1();
    logic [7:0] d;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rd(A_CTRL, d);   chk("R1 ctrl", d, 0);
    rd(A_RELOAD, d); chk("R1 reload", d, 0);
    rd(A_CMP, d);    chk("R1 cmp", d, 0);
    rd(A_LOAD, d);   chk("R1 count", d, 0);
    chk("R1 flags", {ovf_flag, cmp_flag}, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_div1_r2();
    logic [7:0] d;
    do_reset();
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      rd(A_LOAD, d);
      chk("R2 step per clock", d, k);
    end
  endtask

  task automatic t_prescale_r3_r4();
    int g;
    logic [7:0] prev, cur;
    do_reset();
    wr(A_CTRL, 8'h60);
    wait_change(g);
    wait_change(g);
    chk("R3 divide by 8", g, 8);
    // phase known: rewrite control 3 cycles into the period
    rd(A_LOAD, prev);
    g = -1;
    for (int k = 1; k <= 14; k++) begin
      @(negedge clk);
      if (k == 4) begin bus_wr = 1'b0; end
      rd(A_LOAD, cur);
      if (cur != prev && g < 0) g = k;
      if (k == 3) begin bus_addr = A_CTRL; bus_wdata = 8'h60; bus_wr = 1'b1; end
    end
    bus_addr = A_LOAD;
    chk("R4 prescaler phase kept", g, 8);
    wr(A_CTRL, 8'hE0);
    wait_change(g);
    wait_change(g);
    chk("R3 divide by 128", g, 128);
  endtask

  task automatic t_div3_r5();
    int g;
    do_reset();
    wr(A_CTRL, 8'h01);
    wait_change(g);
    wait_change(g); chk("R5 div3 gap a", g, 3);
    wait_change(g); chk("R5 div3 gap b", g, 3);
  endtask

  // 5 full pulses, then one more rise left high: 6 rises, 5 falls
  task automatic ext_run(input logic [7:0] ctrl, input string req, input int exp);
    logic [7:0] d;
    ext_in = 1'b0;
    do_reset();
    wr(A_CTRL, 8'h03);
    wr(A_LOAD, 8'h00);
    wr(A_CTRL, ctrl);
    repeat (5) begin
      ext_in = 1'b1; repeat (4) @(negedge clk);
      ext_in = 1'b0; repeat (4) @(negedge clk);
    end
    ext_in = 1'b1;
    repeat (6) @(negedge clk);
    rd(A_LOAD, d);
    chk(req, d, exp);
    ext_in = 1'b0;
  endtask

  task automatic t_stop_r9();
    logic [7:0] a, b;
    do_reset();
    wr(A_CTRL, 8'h03);
    rd(A_LOAD, a);
    repeat (10) @(negedge clk);
    rd(A_LOAD, b);
    chk("R9 stopped", b, a);
  endtask

  task automatic t_reload_r10_r11();
    logic [7:0] d;
    do_reset();
    wr(A_CTRL, 8'h03);
    wr(A_RELOAD, 8'hF0);
    wr(A_LOAD, 8'hFE);
    rd(A_LOAD, d); chk("R11 load readback", d, 8'hFE);
    chk("R10 ovf low", ovf_flag, 0);
    wr(A_CTRL, 8'h00);
    rd(A_LOAD, d); chk("R10 first", d, 8'hFE);
    @(negedge clk); rd(A_LOAD, d); chk("R10 at max", d, 8'hFF);
    @(negedge clk); rd(A_LOAD, d); chk("R10 reload value", d, 8'hF0);
    chk("R10 ovf set", ovf_flag, 1);
    repeat (3) @(negedge clk);
    chk("R10 ovf sticky", ovf_flag, 1);
    flag_clr = 2'b01;
    @(negedge clk); flag_clr = 2'b00;
    chk("R10 ovf cleared", ovf_flag, 0);
  endtask

  task automatic t_load_r11();
    logic [7:0] d;
    do_reset();
    repeat (3) @(negedge clk);
    wr(A_LOAD, 8'h40);
    rd(A_LOAD, d); chk("R11 load beats step", d, 8'h40);
    @(negedge clk); rd(A_LOAD, d); chk("R11 runs on", d, 8'h41);
  endtask

  task automatic t_cmp_r12();
    logic [7:0] d;
    do_reset();
    wr(A_CTRL, 8'h03);
    wr(A_CMP, 8'h45);
    wr(A_LOAD, 8'h40);
    chk("R12 flag low", cmp_flag, 0);
    wr(A_CTRL, 8'h00);
    repeat (4) @(negedge clk);
    rd(A_LOAD, d); chk("R12 count 44", d, 8'h44);
    chk("R12 not yet", cmp_flag, 0);
    @(negedge clk);
    chk("R12 match set", cmp_flag, 1);
    repeat (3) @(negedge clk);
    chk("R12 sticky", cmp_flag, 1);
    flag_clr = 2'b10;
    @(negedge clk); flag_clr = 2'b00;
    chk("R12 cleared", cmp_flag, 0);
  endtask

  task automatic t_regs_r13_r14();
    logic [7:0] d, a;
    do_reset();
    wr(A_CTRL, 8'h13);
    rd(A_CTRL, d); chk("R13 bit4 reads 0", d, 8'h03);
    rd(A_LOAD, a);
    wr(8'hD8, 8'h55);
    wr(8'hDC, 8'hAA);
    rd(A_RELOAD, d); chk("R14 reload untouched", d, 0);
    rd(A_CMP, d);    chk("R14 cmp untouched", d, 0);
    rd(A_CTRL, d);   chk("R14 ctrl untouched", d, 8'h03);
    rd(A_LOAD, d);   chk("R14 count untouched", d, a);
    rd(8'hD8, d);    chk("R14 unmapped read", d, 0);
    bus_addr = A_LOAD;
  endtask

  initial begin
    t_reset_r1();
    t_div1_r2();
    t_prescale_r3_r4();
    t_div3_r5();
    ext_run(8'h06, "R6 rising edges", 6);
    ext_run(8'h0E, "R7 falling edges", 5);
    ext_run(8'h02, "R8 detection off", 0);
    t_stop_r9();
    t_reload_r10_r11();
    t_load_r11();
    t_cmp_r12();
    t_regs_r13_r14();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule